// File: doc/BRIEF.md
# Dual-Bank Register File with Cross-Side Read and Write Paths

This block holds the general-purpose registers of an eight-unit datapath. The registers sit in two banks, side A and side B, of 16 words of 32 bits each. Units 0 to 3 belong to side A and units 4 to 7 belong to side B. Each unit has two read ports and one write port. A 5-bit register index names a register: bit 4 picks the bank (0 = A, 1 = B) and bits 3:0 pick the word within the bank.

Reads and writes to a unit's own bank need no arbitration. Each side has only one bus into the other bank for reads and one for writes. When several units on one side want the same cross bus in a cycle, the lowest-numbered unit gets it and the side's stall output goes high for that cycle. The caller is expected to hold and retry the losers. A load/store unit that pairs an address from one bank with data from the other simply issues an ordinary cross request. Reads are combinational from the stored state. Writes take effect at the next rising clock edge.

Top module: `rfx_regfile`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to zero. In the first cycle after reset, every read of any register returns zero.
- R2: Read data follow the index presented in the same cycle, with no clock delay. Index bit 4 selects bank B, and bits 3:0 select the word.
- R3: A value written at a clock edge can be read from the next cycle on. A read of a register being written in the current cycle returns the previous contents.
- R4: The first read port of each unit always reads its own side's bank. Bit 4 of that index is ignored.
- R5: A unit requests its side's cross read bus when its active flag is high and bit 4 of its second read index names the other bank. Of the requesters on one side, the lowest-numbered unit gets its `xr_gnt` bit and receives the remote register's value.
- R6: A second-port read that names the other bank returns zero, with its grant bit low, when the unit is inactive or was not granted.
- R7: `x_stall[s]` (bit 0 = side A, bit 1 = side B) is high in every cycle in which two or more units of side s request the cross read bus.
- R8: A write whose destination bank lies on the other side uses that side's single cross write bus. Only the lowest-numbered such writer per side is performed, the others are discarded, and `x_stall` for that side is high.
- R9: When two performed writes name the same register in one cycle, the higher-numbered unit's data are stored and `w_coll` is high in that cycle. `w_coll` is low otherwise.
- R10: All eight units may write registers in their own bank in the same cycle, and every one of those writes is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| u_act | input | 8 | Per-unit active flag qualifying cross read requests |
| u_src0 | input | 8x5 | First read index per unit (bank bit ignored) |
| u_src1 | input | 8x5 | Second read index per unit, may name the other bank |
| u_wen | input | 8 | Per-unit write enable |
| u_wdst | input | 8x5 | Per-unit write index |
| u_wdata | input | 8x32 | Per-unit write data |
| u_rd0 | output | 8x32 | First read port data per unit |
| u_rd1 | output | 8x32 | Second read port data per unit |
| xr_gnt | output | 8 | Cross read grant per unit |
| x_stall | output | 2 | Cross bus contention per side |
| w_coll | output | 1 | Same-register write collision this cycle |

## Verification
A corrupted register shows up on any read port that names it, starting one cycle after the faulty write edge. Each scenario therefore writes a pattern and reads it back through both ports in the following cycle. A fault in the arbiters or in the stall and collision logic is combinational, so it appears on `xr_gnt`, `x_stall`, `w_coll` or a zeroed `u_rd1` in the same cycle as the offending request. A discarded or misdirected cross write appears one cycle later as a wrong value in the target register.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    localparam int NUM_SIDES      = 2;
    localparam int UNITS_PER_SIDE = 4;
    localparam int NUM_UNITS      = NUM_SIDES * UNITS_PER_SIDE;
    localparam int REGS_PER_BANK  = 16;
    localparam int DATA_W         = 32;
    localparam int LOC_W          = $clog2(REGS_PER_BANK);
    localparam int IDX_W          = LOC_W + 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LOC_W-1:0]  loc_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // One write offered to a bank after cross-bus arbitration.
    typedef struct packed {
        logic  en;
        loc_t  loc;
        word_t data;
    } wr_req_t;

    function automatic logic side_of(input int unsigned unit);
        return (unit / UNITS_PER_SIDE) != 0;
    endfunction

    function automatic logic bank_of(input idx_t idx);
        return idx[IDX_W-1];
    endfunction

    function automatic loc_t loc_of(input idx_t idx);
        return idx[LOC_W-1:0];
    endfunction

endpackage

// File: rtl/rfx_arb.sv
// Fixed-priority arbiter: lowest index wins, multi flags contention.
module rfx_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         multi
);

    logic found;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign multi = ($countones(req) > 1);

endmodule

// File: rtl/rfx_bank.sv
// One bank of flop storage with N_WR resolved write ports.
module rfx_bank
    import rfx_pkg::*;
#(
    parameter int N_WR = NUM_UNITS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  wr_req_t [N_WR-1:0]            wr,
    output word_t   [REGS_PER_BANK-1:0]   q,
    output logic                          coll
);

    word_t [REGS_PER_BANK-1:0] nxt;

    // Later (higher-numbered) ports override earlier ones.
    always_comb begin
        nxt = q;
        for (int u = 0; u < N_WR; u++) begin
            if (wr[u].en) nxt[wr[u].loc] = wr[u].data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    always_comb begin
        coll = 1'b0;
        for (int a = 0; a < N_WR; a++) begin
            for (int b = a + 1; b < N_WR; b++) begin
                if (wr[a].en && wr[b].en && (wr[a].loc == wr[b].loc)) coll = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rfx_regfile.sv
module rfx_regfile
    import rfx_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_UNITS-1:0]               u_act,
    input  logic [NUM_UNITS-1:0][IDX_W-1:0]    u_src0,
    input  logic [NUM_UNITS-1:0][IDX_W-1:0]    u_src1,
    input  logic [NUM_UNITS-1:0]               u_wen,
    input  logic [NUM_UNITS-1:0][IDX_W-1:0]    u_wdst,
    input  logic [NUM_UNITS-1:0][DATA_W-1:0]   u_wdata,
    output logic [NUM_UNITS-1:0][DATA_W-1:0]   u_rd0,
    output logic [NUM_UNITS-1:0][DATA_W-1:0]   u_rd1,
    output logic [NUM_UNITS-1:0]               xr_gnt,
    output logic [NUM_SIDES-1:0]               x_stall,
    output logic                               w_coll
);

    localparam int UPS = UNITS_PER_SIDE;

    word_t   [NUM_SIDES-1:0][REGS_PER_BANK-1:0] bank_q;
    wr_req_t [NUM_SIDES-1:0][NUM_UNITS-1:0]     bank_wr;
    logic    [NUM_SIDES-1:0]                    bank_coll;
    logic    [NUM_UNITS-1:0]                    xr_req;
    logic    [NUM_UNITS-1:0]                    xw_req;
    logic    [NUM_UNITS-1:0]                    xw_gnt;
    logic    [NUM_UNITS-1:0]                    wr_ok;
    logic    [NUM_SIDES-1:0]                    xr_multi;
    logic    [NUM_SIDES-1:0]                    xw_multi;

    // Per-unit request decode, read steering and write routing.
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam logic SIDE = side_of(u);

        logic src1_local;
        logic dst_local;

        assign src1_local = (bank_of(u_src1[u]) == SIDE);
        assign dst_local  = (bank_of(u_wdst[u]) == SIDE);

        assign xr_req[u] = u_act[u] && !src1_local;
        assign xw_req[u] = u_wen[u] && !dst_local;
        assign wr_ok[u]  = u_wen[u] && (dst_local || xw_gnt[u]);

        assign u_rd0[u] = bank_q[SIDE][loc_of(u_src0[u])];
        assign u_rd1[u] = src1_local ? bank_q[SIDE][loc_of(u_src1[u])]
                        : xr_gnt[u]  ? bank_q[!SIDE][loc_of(u_src1[u])]
                        : '0;

        for (genvar b = 0; b < NUM_SIDES; b++) begin : g_route
            assign bank_wr[b][u] = '{
                en:   wr_ok[u] && (bank_of(u_wdst[u]) == 1'(b)),
                loc:  loc_of(u_wdst[u]),
                data: u_wdata[u]
            };
        end
    end

    // Per-side cross bus arbiters and storage.
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        rfx_arb #(.N(UPS)) i_rd_arb (
            .req   (xr_req[s*UPS +: UPS]),
            .gnt   (xr_gnt[s*UPS +: UPS]),
            .multi (xr_multi[s])
        );

        rfx_arb #(.N(UPS)) i_wr_arb (
            .req   (xw_req[s*UPS +: UPS]),
            .gnt   (xw_gnt[s*UPS +: UPS]),
            .multi (xw_multi[s])
        );

        rfx_bank #(.N_WR(NUM_UNITS)) i_bank (
            .clk  (clk),
            .rst  (rst),
            .wr   (bank_wr[s]),
            .q    (bank_q[s]),
            .coll (bank_coll[s])
        );

        assign x_stall[s] = xr_multi[s] | xw_multi[s];
    end

    assign w_coll = |bank_coll;

endmodule

// File: rtl/rfx_regfile_chk.sv
module rfx_regfile_chk
    import rfx_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_UNITS-1:0]               u_act,
    input  logic [NUM_UNITS-1:0][IDX_W-1:0]    u_src0,
    input  logic [NUM_UNITS-1:0][IDX_W-1:0]    u_src1,
    input  logic [NUM_UNITS-1:0]               u_wen,
    input  logic [NUM_UNITS-1:0][IDX_W-1:0]    u_wdst,
    input  logic [NUM_UNITS-1:0][DATA_W-1:0]   u_wdata,
    input  logic [NUM_UNITS-1:0][DATA_W-1:0]   u_rd0,
    input  logic [NUM_UNITS-1:0][DATA_W-1:0]   u_rd1,
    input  logic [NUM_UNITS-1:0]               xr_gnt,
    input  logic [NUM_SIDES-1:0]               x_stall,
    input  logic                               w_coll
);

    localparam int UPS = UNITS_PER_SIDE;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_s
        logic [UPS-1:0] rreq;
        for (genvar k = 0; k < UPS; k++) begin : g_k
            assign rreq[k] = u_act[s*UPS+k] && (u_src1[s*UPS+k][IDX_W-1] != 1'(s));
        end

        a_r5_one_grant_per_side: assert property (@(posedge clk) disable iff (rst)
            $onehot0(xr_gnt[s*UPS +: UPS]));

        a_r7_stall_on_contention: assert property (@(posedge clk) disable iff (rst)
            ($countones(rreq) > 1) |-> x_stall[s]);
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
        localparam logic SIDE = side_of(u);

        a_r5_grant_needs_request: assert property (@(posedge clk) disable iff (rst)
            xr_gnt[u] |-> (u_act[u] && (u_src1[u][IDX_W-1] != SIDE)));

        a_r6_denied_read_zero: assert property (@(posedge clk) disable iff (rst)
            ((u_src1[u][IDX_W-1] != SIDE) && !xr_gnt[u]) |-> (u_rd1[u] == '0));
    end

    a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (u_rd0 == '0));

    // Unit 0 writes its own bank; with no collision the value must land.
    a_r3_local_write_lands: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && u_wen[0] && !u_wdst[0][IDX_W-1] && !w_coll)
         && (u_src0[0][LOC_W-1:0] == $past(u_wdst[0][LOC_W-1:0])))
        |-> (u_rd0[0] == $past(u_wdata[0])));

endmodule

bind rfx_regfile rfx_regfile_chk i_chk (.*);

// File: tb/test_rfx_regfile.sv
module test_rfx_regfile;
    import rfx_pkg::*;

    localparam int NU  = NUM_UNITS;
    localparam int UPS = UNITS_PER_SIDE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NU-1:0]               u_act;
    logic [NU-1:0][IDX_W-1:0]    u_src0, u_src1, u_wdst;
    logic [NU-1:0]               u_wen;
    logic [NU-1:0][DATA_W-1:0]   u_wdata;
    logic [NU-1:0][DATA_W-1:0]   u_rd0, u_rd1;
    logic [NU-1:0]               xr_gnt;
    logic [NUM_SIDES-1:0]        x_stall;
    logic                        w_coll;

    rfx_regfile i_rfx_regfile (.*);

    typedef struct {
        string                     tag;
        logic [NU-1:0][DATA_W-1:0] rd0;
        logic [NU-1:0][DATA_W-1:0] rd1;
        logic [NU-1:0]             gnt;
        logic [NUM_SIDES-1:0]      stall;
        logic                      coll;
    } exp_t;

    word_t model [2*REGS_PER_BANK];
    exp_t  sbq[$];
    exp_t  mon_e;
    int    n_cmp = 0;
    int    n_bad = 0;

    task automatic chk(input string tag, input string what,
                       input logic [NU*DATA_W-1:0] act, input logic [NU*DATA_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare the oldest expected item at the falling edge.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            mon_e = sbq.pop_front();
            chk(mon_e.tag, "rd0",   u_rd0,   mon_e.rd0);
            chk(mon_e.tag, "rd1",   u_rd1,   mon_e.rd1);
            chk(mon_e.tag, "gnt",   xr_gnt,  mon_e.gnt);
            chk(mon_e.tag, "stall", x_stall, mon_e.stall);
            chk(mon_e.tag, "coll",  w_coll,  mon_e.coll);
        end
    end

    // Driver: predict from the requirements, push, then advance one edge.
    task automatic step(input string tag);
        exp_t e;
        int fr[NUM_SIDES], fw[NUM_SIDES], nr[NUM_SIDES], nw[NUM_SIDES];
        logic [NU-1:0] eff;
        e.tag = tag;
        e.coll = 1'b0;
        for (int s = 0; s < NUM_SIDES; s++) begin
            fr[s] = -1; fw[s] = -1; nr[s] = 0; nw[s] = 0;
        end
        for (int u = 0; u < NU; u++) begin
            int  s;
            logic sd;
            s = u / UPS; sd = 1'(s);
            if (u_act[u] && u_src1[u][4] != sd) begin
                if (fr[s] < 0) fr[s] = u;
                nr[s]++;
            end
            if (u_wen[u] && u_wdst[u][4] != sd) begin
                if (fw[s] < 0) fw[s] = u;
                nw[s]++;
            end
        end
        for (int u = 0; u < NU; u++) begin
            int  s;
            logic sd;
            s = u / UPS; sd = 1'(s);
            e.rd0[u] = model[{sd, u_src0[u][3:0]}];
            e.gnt[u] = (fr[s] == u);
            if (u_src1[u][4] == sd || fr[s] == u) e.rd1[u] = model[u_src1[u]];
            else                                  e.rd1[u] = '0;
            eff[u] = u_wen[u] && (u_wdst[u][4] == sd || fw[s] == u);
        end
        for (int s = 0; s < NUM_SIDES; s++) e.stall[s] = (nr[s] > 1) || (nw[s] > 1);
        for (int a = 0; a < NU; a++)
            for (int b = a + 1; b < NU; b++)
                if (eff[a] && eff[b] && u_wdst[a] == u_wdst[b]) e.coll = 1'b1;
        sbq.push_back(e);
        @(posedge clk);
        for (int u = 0; u < NU; u++) if (eff[u]) model[u_wdst[u]] = u_wdata[u];
        #1;
    endtask

    task automatic idle();
        u_act = '0; u_src0 = '0; u_src1 = '0; u_wen = '0; u_wdst = '0; u_wdata = '0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hang expected finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2*REGS_PER_BANK; i++) model[i] = '0;
        idle();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: everything zero straight after reset.
        for (int u = 0; u < NU; u++) begin
            u_src0[u] = 5'(u); u_src1[u] = {1'(u / UPS), 4'(u + 8)};
        end
        step("R1 reset clears registers");

        // R10 + R3: eight simultaneous local writes; same-cycle read sees old value.
        for (int u = 0; u < NU; u++) begin
            u_wen[u] = 1'b1; u_wdst[u] = {1'(u / UPS), 4'(u)};
            u_wdata[u] = 32'hA5000000 + 32'(u * 32'h1111);
            u_src0[u] = {1'(u / UPS), 4'(u)};
        end
        step("R10 R3 all local writes, read returns old value");
        idle();

        // R2: read back in the next cycle with no delay.
        for (int u = 0; u < NU; u++) begin
            u_src0[u] = {1'(u / UPS), 4'(u)}; u_src1[u] = {1'(u / UPS), 4'((u + 1) % 8)};
        end
        step("R2 R3 readback of written values");

        // R4: first port ignores the bank bit.
        for (int u = 0; u < NU; u++) u_src0[u] = {~1'(u / UPS), 4'(u)};
        step("R4 first port stays local");
        idle();

        // R5: one cross read per side.
        u_act[2] = 1'b1; u_src1[2] = {1'b1, 4'd4};
        u_act[6] = 1'b1; u_src1[6] = {1'b0, 4'd1};
        step("R5 single cross read each side");
        idle();

        // R6 + R7: contention on side A, an inactive remote read on side B.
        u_act[1] = 1'b1; u_src1[1] = {1'b1, 4'd5};
        u_act[3] = 1'b1; u_src1[3] = {1'b1, 4'd6};
        u_act[0] = 1'b0; u_src1[0] = {1'b1, 4'd7};
        u_act[4] = 1'b0; u_src1[4] = {1'b0, 4'd2};
        step("R6 R7 side A contention, lowest wins");
        idle();

        // R8: two cross writes from side B; only unit 5 lands.
        u_wen[5] = 1'b1; u_wdst[5] = {1'b0, 4'd9};  u_wdata[5] = 32'h0BAD5005;
        u_wen[7] = 1'b1; u_wdst[7] = {1'b0, 4'd10}; u_wdata[7] = 32'h0BAD7007;
        step("R8 cross write contention");
        idle();
        u_src0[0] = {1'b0, 4'd9}; u_src0[1] = {1'b0, 4'd10};
        step("R8 only lowest cross writer stored");
        idle();

        // R9: same-register collisions, higher unit wins.
        u_wen[1] = 1'b1; u_wdst[1] = {1'b0, 4'd3}; u_wdata[1] = 32'h11111111;
        u_wen[6] = 1'b1; u_wdst[6] = {1'b0, 4'd3}; u_wdata[6] = 32'h66666666;
        u_wen[2] = 1'b1; u_wdst[2] = {1'b0, 4'd4}; u_wdata[2] = 32'h22222222;
        u_wen[3] = 1'b1; u_wdst[3] = {1'b0, 4'd4}; u_wdata[3] = 32'h33333333;
        step("R9 write collision flagged");
        idle();
        u_src0[0] = {1'b0, 4'd3}; u_src0[1] = {1'b0, 4'd4};
        step("R9 higher-numbered writer kept");
        idle();

        // Mixed random traffic across all requirements.
        for (int n = 0; n < 400; n++) begin
            for (int u = 0; u < NU; u++) begin
                u_act[u]   = 1'($urandom);
                u_src0[u]  = 5'($urandom);
                u_src1[u]  = 5'($urandom);
                u_wen[u]   = 1'($urandom);
                u_wdst[u]  = 5'($urandom);
                u_wdata[u] = $urandom;
            end
            step("R2 R5 R7 R8 R9 random traffic");
        end
        idle();
        step("R3 final readback");

        @(negedge clk);
        #1;
        finish_run();
    end

endmodule